// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Character Receiver

This block recovers characters from a single asynchronous serial line. The line rests at logic high. A character starts with a low start bit, carries eight data bits least significant bit first, can carry one parity bit, and ends with one or two high stop bits. The transmitter's clock has no relation to the local one. The receiver therefore runs from its own system clock and advances only on an oversample tick enable, which runs at 16 or 32 ticks per bit.

A falling edge on the synchronized line arms the receiver. It then waits half a bit period of ticks and checks the start bit at its centre. A line that has already returned high at that point counts as a glitch and is discarded silently. From the start-bit centre, every later bit is sampled one full bit period after the one before. The byte is released only if every stop bit reads high. A low stop bit discards the character and raises a framing error. Parity can be none, even or odd, and a parity mismatch is flagged together with the delivered byte. The oversample ratio, stop-bit count and parity mode are captured at the start edge, so a change in the middle of a character does not disturb it.

Top module: `async_serial_rx`

## Requirements
- R1: After synchronous reset, and while the line stays high, rx_valid, frame_err and parity_err stay 0 and rx_data is 0. A reset during a character abandons that character without reporting anything.
- R2: Only a high-to-low transition arms reception. If the line is high again at the start-bit centre, which is half a bit period of ticks after the edge, the receiver returns to idle and pulses no output.
- R3: Eight data bits are taken least significant bit first. A good character appears on rx_data with a one-cycle rx_valid pulse.
- R4: os_sel=0 selects 16 ticks per bit (8 to the start centre) and os_sel=1 selects 32 ticks per bit (16 to the start centre). Characters timed for the selected ratio are received correctly.
- R5: With two_stop=1, both stop bits must be high. A low second stop bit gives frame_err and no rx_valid.
- R6: A low first stop bit gives a one-cycle frame_err pulse and no rx_valid, and rx_data keeps the last delivered byte. frame_err and rx_valid never pulse together.
- R7: parity_mode 2'd0 and 2'd3 mean no parity bit, 2'd1 means even parity (data plus parity bit hold an even number of ones), and 2'd2 means odd parity. The parity bit follows bit 7.
- R8: A parity mismatch on an otherwise good character pulses parity_err in the same cycle as rx_valid. parity_err never pulses alone, including when the character has a framing error.
- R9: Characters may follow each other with no idle gap at all. After a framing error with the line held low, no new character is armed until the line has gone high and then fallen again.
- R10: The receiver does not advance while tick_en is low. A line pulse that occurs entirely between ticks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Oversample tick, one clk cycle wide |
| os_sel | input | 1 | 0: 16 ticks per bit, 1: 32 ticks per bit |
| two_stop | input | 1 | 1: two stop bits expected |
| parity_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last good byte received |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| parity_err | output | 1 | One-cycle pulse with rx_valid on parity mismatch |

## Verification
The byte strobe and the parity error are two functions that share the same final stop-bit sample, so both must land in the same clock cycle. The bench provokes this by sending characters in even and odd mode with the parity bit inverted. It counts rx_valid and parity_err pulses and also counts every cycle in which parity_err is high without rx_valid. That count must stay zero, including for a character that has both a wrong parity bit and a bad stop bit, where only frame_err may appear.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5
  } rx_state_e;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  function automatic logic par_present(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

  // expected parity bit given XOR reduction of the data
  function automatic logic par_bit_for(input logic [1:0] mode, input logic data_xor);
    return (mode == PAR_ODD) ? ~data_xor : data_xor;
  endfunction

endpackage

// File: rtl/async_rx_line_sync.sv
module async_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic rxd,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], rxd};
  end

  assign line_s = chain[STAGES-1];

  // level seen at the previous tick; edges are judged tick to tick
  always_ff @(posedge clk) begin
    if (rst)          prev_lvl <= 1'b1;
    else if (tick_en) prev_lvl <= line_s;
  end

  assign fall = tick_en && prev_lvl && !line_s;

  // after an edge the tick-sampled level is low, so two edges cannot abut
  assert_fall_isolated_R2: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/async_rx_bit_timer.sv
module async_rx_bit_timer #(
  parameter int OS_LO = 16,
  parameter int OS_HI = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic clr,
  input  logic half_sel,
  input  logic os_hi_sel,
  output logic hit
);
  localparam int CNT_W = $clog2(OS_HI);
  localparam int LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [LIM_W-1:0] full_per;
  logic [LIM_W-1:0] lim;

  always_comb begin
    full_per = os_hi_sel ? LIM_W'(OS_HI) : LIM_W'(OS_LO);
    lim      = (half_sel ? (full_per >> 1) : full_per) - LIM_W'(1);
    hit      = tick_en && !clr && ({1'b0, cnt} == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (tick_en) cnt <= hit ? '0 : cnt + CNT_W'(1);
  end

  assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |-> ({1'b0, cnt} <= lim));

endmodule

// File: rtl/async_rx_frame_ctrl.sv
module async_rx_frame_ctrl
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 fall,
  input  logic                 line_s,
  input  logic                 hit,
  input  logic                 os_sel,
  input  logic                 two_stop,
  input  logic [1:0]           parity_mode,
  output logic                 timer_clr,
  output logic                 half_sel,
  output logic                 os_hi_q,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 parity_err
);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  rx_state_e            state;
  logic [BIT_W-1:0]     bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_q;
  logic                 two_q;
  logic [1:0]           mode_q;
  logic                 done_ok;
  logic                 stop_bad;
  logic                 in_stop;

  assign timer_clr = (state == ST_IDLE);
  assign half_sel  = (state == ST_START);

  always_comb begin
    in_stop  = (state == ST_STOP1) || (state == ST_STOP2);
    done_ok  = hit && line_s &&
               ((state == ST_STOP2) || (state == ST_STOP1 && !two_q));
    stop_bad = hit && !line_s && in_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
      par_q   <= 1'b0;
      two_q   <= 1'b0;
      mode_q  <= PAR_NONE;
      os_hi_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (fall) begin
          state   <= ST_START;
          os_hi_q <= os_sel;
          two_q   <= two_stop;
          mode_q  <= parity_mode;
        end
        ST_START: if (hit) begin
          if (line_s) state <= ST_IDLE;
          else begin
            state   <= ST_DATA;
            bit_idx <= '0;
          end
        end
        ST_DATA: if (hit) begin
          shreg <= {line_s, shreg[DATA_BITS-1:1]};
          if (bit_idx == LAST_BIT)
            state <= par_present(mode_q) ? ST_PAR : ST_STOP1;
          else
            bit_idx <= bit_idx + BIT_W'(1);
        end
        ST_PAR: if (hit) begin
          par_q <= line_s;
          state <= ST_STOP1;
        end
        ST_STOP1: if (hit) begin
          if (!line_s || !two_q) state <= ST_IDLE;
          else                   state <= ST_STOP2;
        end
        ST_STOP2: if (hit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // registered result strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      rx_valid   <= done_ok;
      frame_err  <= stop_bad;
      parity_err <= done_ok && par_present(mode_q) &&
                    (par_q != par_bit_for(mode_q, ^shreg));
      if (done_ok) rx_data <= shreg;
    end
  end

  assert_perr_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
    parity_err |-> rx_valid);

  assert_valid_ferr_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && frame_err));

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_glitch_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && hit && line_s) |=> (!rx_valid && !frame_err && state == ST_IDLE));

  assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(state));

endmodule

// File: rtl/async_serial_rx.sv
module async_serial_rx #(
  parameter int OS_LO       = 16,
  parameter int OS_HI       = 32,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 os_sel,
  input  logic                 two_stop,
  input  logic [1:0]           parity_mode,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 parity_err
);
  logic line_s;
  logic fall;
  logic hit;
  logic timer_clr;
  logic half_sel;
  logic os_hi_q;

  async_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .rxd     (rxd),
    .line_s  (line_s),
    .fall    (fall)
  );

  async_rx_bit_timer #(.OS_LO(OS_LO), .OS_HI(OS_HI)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .clr       (timer_clr),
    .half_sel  (half_sel),
    .os_hi_sel (os_hi_q),
    .hit       (hit)
  );

  async_rx_frame_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .fall        (fall),
    .line_s      (line_s),
    .hit         (hit),
    .os_sel      (os_sel),
    .two_stop    (two_stop),
    .parity_mode (parity_mode),
    .timer_clr   (timer_clr),
    .half_sel    (half_sel),
    .os_hi_q     (os_hi_q),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .frame_err   (frame_err),
    .parity_err  (parity_err)
  );

endmodule

// File: tb/test_async_serial_rx.sv
module test_async_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 2;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 12;

  // [17] os_sel [16] two_stop [15:14] parity_mode [13:6] data
  // [5] flip parity [4] bad stop1 [3] bad stop2 [2] exp valid [1] exp ferr [0] exp perr
  localparam logic [17:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 2'd0, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'd0, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 2'd1, 8'hB7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 2'd2, 8'hB7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 2'd1, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b0, 2'd2, 8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 1'b0, 2'd3, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'd0, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'd0, 8'h12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd2, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       tick_on = 1'b1;
  logic       os_sel = 1'b0;
  logic       two_stop = 1'b0;
  logic [1:0] parity_mode = 2'd0;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, parity_err;

  int n_valid = 0, n_ferr = 0, n_perr = 0, n_orphan = 0;
  logic [7:0] got = 8'h00;
  int total = 0, passed = 0;
  logic [7:0] last_good = 8'h00;

  async_serial_rx i_async_serial_rx (
    .clk(clk), .rst(rst), .tick_en(tick_en), .os_sel(os_sel), .two_stop(two_stop),
    .parity_mode(parity_mode), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .parity_err(parity_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) tick_en <= tick_on && !tick_en;

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (rx_valid) begin n_valid++; got = rx_data; end
      if (frame_err) n_ferr++;
      if (parity_err) n_perr++;
      if (parity_err && !rx_valid) n_orphan++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act == exp) passed++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic clr_mon();
    @(negedge clk);
    n_valid = 0; n_ferr = 0; n_perr = 0; n_orphan = 0;
  endtask

  task automatic hold(input logic lvl, input int ncyc);
    @(negedge clk);
    rxd = lvl;
    repeat (ncyc - 1) @(negedge clk);
  endtask

  task automatic send(input int os, input logic [7:0] d, input logic [1:0] pm,
                      input logic flip, input int nstop, input logic s1, input logic s2);
    int bp;
    bp = os * TDIV;
    hold(1'b0, bp);
    for (int i = 0; i < 8; i++) hold(d[i], bp);
    if (pm == 2'd1) hold((^d) ^ flip, bp);
    if (pm == 2'd2) hold((~^d) ^ flip, bp);
    hold(s1, bp);
    if (nstop == 2) hold(s2, bp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    // R1: quiet after reset with idle line
    chk("R1 valid", n_valid + int'(rx_valid), 0);
    chk("R1 ferr", n_ferr + int'(frame_err), 0);
    chk("R1 data", int'(rx_data), 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [17:0] e;
      int os;
      e = VECS[v];
      os = e[17] ? 32 : 16;
      os_sel = e[17]; two_stop = e[16]; parity_mode = e[15:14];
      clr_mon();
      send(os, e[13:6], e[15:14], e[5], e[16] ? 2 : 1, !e[4], !e[3]);
      hold(1'b1, 3 * os * TDIV);
      chk($sformatf("R3/R4/R5 valid vec%0d", v), n_valid, int'(e[2]));
      chk($sformatf("R6 ferr vec%0d", v), n_ferr, int'(e[1]));
      chk($sformatf("R7 perr vec%0d", v), n_perr, int'(e[0]));
      if (e[2]) last_good = e[13:6];
      chk($sformatf("R3 data vec%0d", v), int'(rx_data), int'(last_good));
    end
    chk("R8 orphan perr", n_orphan, 0);

    // R2: short glitch (3 ticks) ignored
    os_sel = 1'b0; two_stop = 1'b0; parity_mode = 2'd0;
    clr_mon();
    hold(1'b0, 3 * TDIV);
    hold(1'b1, 64 * TDIV);
    chk("R2 glitch valid", n_valid, 0);
    chk("R2 glitch ferr", n_ferr, 0);
    send(16, 8'h6B, 2'd0, 1'b0, 1, 1'b1, 1'b1);
    hold(1'b1, 48 * TDIV);
    chk("R2 after glitch data", int'(got), 8'h6B);

    // R9: back-to-back with no gap
    clr_mon();
    send(16, 8'hC3, 2'd0, 1'b0, 1, 1'b1, 1'b1);
    send(16, 8'h5A, 2'd0, 1'b0, 1, 1'b1, 1'b1);
    hold(1'b1, 48 * TDIV);
    chk("R9 b2b count", n_valid, 2);
    chk("R9 b2b data", int'(got), 8'h5A);

    // R9: line held low after framing error
    clr_mon();
    send(16, 8'h00, 2'd0, 1'b0, 1, 1'b0, 1'b0);
    hold(1'b0, 48 * TDIV);
    hold(1'b1, 32 * TDIV);
    send(16, 8'h99, 2'd0, 1'b0, 1, 1'b1, 1'b1);
    hold(1'b1, 48 * TDIV);
    chk("R9 low hold ferr", n_ferr, 1);
    chk("R9 low hold valid", n_valid, 1);
    chk("R9 low hold data", int'(got), 8'h99);

    // R10: pulse while ticks stopped
    clr_mon();
    @(negedge clk); tick_on = 1'b0;
    repeat (4) @(negedge clk);
    hold(1'b0, 200);
    hold(1'b1, 20);
    tick_on = 1'b1;
    hold(1'b1, 64 * TDIV);
    chk("R10 no tick valid", n_valid, 0);
    chk("R10 no tick ferr", n_ferr, 0);
    chk("R10 no tick data", int'(rx_data), 8'h99);

    // R1: reset mid-character
    clr_mon();
    fork
      send(16, 8'h24, 2'd0, 1'b0, 1, 1'b1, 1'b1);
      begin
        repeat (5 * 16 * TDIV) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
      end
    join
    hold(1'b1, 48 * TDIV);
    chk("R1 mid reset valid", n_valid, 0);
    chk("R1 mid reset data", int'(rx_data), 0);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule